// File: doc/BRIEF.md
# NMI-Aware Interrupt Acknowledge Unit

This block sits in the CPU-side interrupt interface. It answers two kinds of acknowledge read. The first is the ordinary group-1 acknowledge. The second is a separate acknowledge reserved for non-maskable interrupts (NMIs). Every cycle, the unit takes the following inputs:

- the highest-priority pending interrupt: its ID, priority, group and NMI flag;
- the priority mask;
- the running priority;
- the binary-point mask;
- one active-NMI flag for each group-1 group;
- the current security state;
- a configuration bit that disables security;
- the NMI enable of the current exception level.

From these inputs it decides whether the pending interrupt may preempt the current work. An ordinary interrupt is held back by the priority mask. An NMI passes the mask, with two exceptions, both for a non-secure group-1 NMI while security is enabled: it is masked when the mask is below 0x80, and also when the CPU is in secure state and the mask equals 0x80.

The ordinary port does not hand an enabled NMI to software. It returns the reserved ID 1022 in its place and leaves the interrupt pending. The NMI port accepts only NMIs.

When a read results in activation, the unit sends a one-cycle pulse to the active-priority tracker. The pulse carries the interrupt ID, its group and its NMI flag.

A small state machine controls the reads. It has three states: `ST_IDLE`, `ST_NORMAL_RESP` and `ST_NMI_RESP`. The transitions are:

- From `ST_IDLE`, a strobe on `rd_normal` moves the machine to `ST_NORMAL_RESP`.
- From `ST_IDLE`, a strobe on `rd_nmi` while `rd_normal` is low moves it to `ST_NMI_RESP`.
- Each response state returns to `ST_IDLE` unconditionally after one cycle.

When the machine takes a read, it registers the decision for that read.

Top module: `nmi_ack_unit`

## Requirements
- R1: A read strobe seen in idle produces `ack_valid` for exactly one cycle, in the cycle after the strobe. Strobes that arrive while a response is showing are ignored. When both strobes are high together, the ordinary read wins.
- R2: If there is no valid pending interrupt, or it cannot preempt, both reads return 1023 and nothing is activated.
- R3: A non-NMI interrupt is masked when its priority is greater than or equal to `pmr`.
- R4: An NMI ignores `pmr`, except when it is non-secure group 1 (group code 2) and `sec_disabled` is 0. Such an NMI is masked when `pmr` < 0x80, and also when `cpu_secure` is 1 and `pmr` equals 0x80. Group codes: 0 = group 0, 1 = secure group 1, 2 = non-secure group 1.
- R5: A non-NMI interrupt preempts only when (`prio` & `bpr_mask`) is strictly below `rpr`.
- R6: An NMI also preempts when (`prio` & `bpr_mask`) equals (`rpr` & `bpr_mask`), but only if the active-NMI flag of its own group is clear. The flag for group 1 is `act_nmi_g1s`; the flag for group 2 is `act_nmi_g1ns`.
- R7: An ordinary read of a preempting NMI returns 1022 and does not activate when `nmi_en` is 1. When `nmi_en` is 0, it returns the real ID and activates.
- R8: An NMI read of a preempting non-NMI returns 1023 and does not activate. An NMI read of a preempting NMI returns its real ID and activates.
- R9: Pending IDs 1020 to 1023 are returned unchanged and are never activated by either read.
- R10: `act_pulse` lasts one cycle and coincides with `ack_valid`. `act_id` equals `ack_id`, and `act_grp` and `act_nmi` copy the pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_normal | input | 1 | Ordinary group-1 acknowledge strobe |
| rd_nmi | input | 1 | NMI acknowledge strobe |
| hppi_valid | input | 1 | A pending interrupt is present |
| hppi_id | input | 10 | Pending interrupt ID |
| hppi_prio | input | 8 | Pending interrupt priority |
| hppi_grp | input | 2 | Pending group (0 = group 0, 1 = secure group 1, 2 = non-secure group 1) |
| hppi_nmi | input | 1 | Pending interrupt is an NMI |
| pmr | input | 8 | Priority mask |
| rpr | input | 8 | Running priority |
| bpr_mask | input | 8 | Group-priority mask from the binary point |
| act_nmi_g1s | input | 1 | An NMI is active in secure group 1 |
| act_nmi_g1ns | input | 1 | An NMI is active in non-secure group 1 |
| cpu_secure | input | 1 | CPU is in secure state |
| sec_disabled | input | 1 | Security is disabled |
| nmi_en | input | 1 | NMI enable of the current exception level |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_id | output | 10 | Returned ID |
| act_pulse | output | 1 | Activate pulse to the tracker |
| act_id | output | 10 | ID being activated |
| act_grp | output | 2 | Group being activated |
| act_nmi | output | 1 | Activated interrupt is an NMI |

## Verification
Every result is due exactly one clock edge after the strobe. The strobe edge registers the decision, and `ack_valid`, `ack_id` and the activate signals appear in the following cycle. They fall at the next edge. The bench drives inputs on the falling edge and raises the strobe for one cycle. It samples the results on the next falling edge, which lies between the capturing edge and the edge that clears them. One further falling edge later, it confirms that the response and the pulse have gone again.

// File: rtl/nmi_ack_pkg.sv
package nmi_ack_pkg;
    localparam int ID_W = 10;
    typedef logic [ID_W-1:0] intid_t;

    localparam intid_t ID_SPECIAL_LO = intid_t'(1020);
    localparam intid_t ID_NMI_RSVD   = intid_t'(1022);
    localparam intid_t ID_SPURIOUS   = intid_t'(1023);

    typedef enum logic [1:0] {
        GRP_0   = 2'b00,
        GRP_1S  = 2'b01,
        GRP_1NS = 2'b10
    } grp_t;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'b00,
        ST_NORMAL_RESP = 2'b01,
        ST_NMI_RESP    = 2'b10
    } state_t;
endpackage

// File: rtl/nmi_mask_check.sv
module nmi_mask_check
    import nmi_ack_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0] pmr,
    input  logic              is_nmi,
    input  grp_t              grp,
    input  logic              cpu_secure,
    input  logic              sec_disabled,
    output logic              masked
);
    // Half-range mask value that fences non-secure NMIs
    localparam logic [PRIO_W-1:0] NS_NMI_FLOOR = PRIO_W'(1) << (PRIO_W - 1);

    logic ns_nmi_guarded;

    always_comb begin
        ns_nmi_guarded = !sec_disabled && (grp == GRP_1NS);
        if (is_nmi) begin
            if (ns_nmi_guarded)
                masked = (pmr < NS_NMI_FLOOR) || (cpu_secure && (pmr == NS_NMI_FLOOR));
            else
                masked = 1'b0;
        end else begin
            masked = (prio >= pmr);
        end
    end
endmodule

// File: rtl/nmi_preempt_check.sv
module nmi_preempt_check
    import nmi_ack_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0] rpr,
    input  logic [PRIO_W-1:0] bpr_mask,
    input  logic              is_nmi,
    input  grp_t              grp,
    input  logic              act_nmi_g1s,
    input  logic              act_nmi_g1ns,
    output logic              preempt
);
    logic [PRIO_W-1:0] grp_prio;
    logic [PRIO_W-1:0] run_grp;
    logic              own_nmi_active;

    always_comb begin
        grp_prio = prio & bpr_mask;
        run_grp  = rpr & bpr_mask;
        unique case (grp)
            GRP_1S:  own_nmi_active = act_nmi_g1s;
            GRP_1NS: own_nmi_active = act_nmi_g1ns;
            default: own_nmi_active = 1'b0;
        endcase
        preempt = (grp_prio < rpr) ||
                  (is_nmi && (grp_prio == run_grp) && !own_nmi_active);
    end
endmodule

// File: rtl/nmi_ack_resolve.sv
module nmi_ack_resolve
    import nmi_ack_pkg::*;
(
    input  logic   pend_valid,
    input  logic   masked,
    input  logic   preempt,
    input  intid_t pend_id,
    input  logic   is_nmi,
    input  logic   nmi_en,
    output intid_t normal_id,
    output logic   normal_act,
    output intid_t nmi_id,
    output logic   nmi_act
);
    logic can_take;
    logic special;

    always_comb begin
        can_take = pend_valid && !masked && preempt;
        special  = (pend_id >= ID_SPECIAL_LO);

        normal_id  = ID_SPURIOUS;
        normal_act = 1'b0;
        nmi_id     = ID_SPURIOUS;
        nmi_act    = 1'b0;

        if (can_take) begin
            if (special) begin
                normal_id = pend_id;
                nmi_id    = pend_id;
            end else begin
                if (is_nmi && nmi_en) begin
                    normal_id = ID_NMI_RSVD;
                end else begin
                    normal_id  = pend_id;
                    normal_act = 1'b1;
                end
                if (is_nmi) begin
                    nmi_id  = pend_id;
                    nmi_act = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/nmi_ack_unit.sv
module nmi_ack_unit
    import nmi_ack_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_normal,
    input  logic              rd_nmi,
    input  logic              hppi_valid,
    input  logic [ID_W-1:0]   hppi_id,
    input  logic [PRIO_W-1:0] hppi_prio,
    input  logic [1:0]        hppi_grp,
    input  logic              hppi_nmi,
    input  logic [PRIO_W-1:0] pmr,
    input  logic [PRIO_W-1:0] rpr,
    input  logic [PRIO_W-1:0] bpr_mask,
    input  logic              act_nmi_g1s,
    input  logic              act_nmi_g1ns,
    input  logic              cpu_secure,
    input  logic              sec_disabled,
    input  logic              nmi_en,
    output logic              ack_valid,
    output logic [ID_W-1:0]   ack_id,
    output logic              act_pulse,
    output logic [ID_W-1:0]   act_id,
    output logic [1:0]        act_grp,
    output logic              act_nmi
);
    grp_t   grp_in;
    logic   masked;
    logic   preempt;
    intid_t normal_id;
    intid_t nmi_id;
    logic   normal_act;
    logic   nmi_act;

    state_t state_q;
    state_t state_d;
    intid_t id_q;
    logic   act_q;
    grp_t   grp_q;
    logic   nmi_q;

    assign grp_in = grp_t'(hppi_grp);

    nmi_mask_check #(.PRIO_W(PRIO_W)) u_mask (
        .prio         (hppi_prio),
        .pmr          (pmr),
        .is_nmi       (hppi_nmi),
        .grp          (grp_in),
        .cpu_secure   (cpu_secure),
        .sec_disabled (sec_disabled),
        .masked       (masked)
    );

    nmi_preempt_check #(.PRIO_W(PRIO_W)) u_preempt (
        .prio         (hppi_prio),
        .rpr          (rpr),
        .bpr_mask     (bpr_mask),
        .is_nmi       (hppi_nmi),
        .grp          (grp_in),
        .act_nmi_g1s  (act_nmi_g1s),
        .act_nmi_g1ns (act_nmi_g1ns),
        .preempt      (preempt)
    );

    nmi_ack_resolve u_resolve (
        .pend_valid (hppi_valid),
        .masked     (masked),
        .preempt    (preempt),
        .pend_id    (hppi_id),
        .is_nmi     (hppi_nmi),
        .nmi_en     (nmi_en),
        .normal_id  (normal_id),
        .normal_act (normal_act),
        .nmi_id     (nmi_id),
        .nmi_act    (nmi_act)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_normal)
                    state_d = ST_NORMAL_RESP;
                else if (rd_nmi)
                    state_d = ST_NMI_RESP;
            end
            ST_NORMAL_RESP: state_d = ST_IDLE;
            ST_NMI_RESP:    state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // State register and captured decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            id_q    <= ID_SPURIOUS;
            act_q   <= 1'b0;
            grp_q   <= GRP_0;
            nmi_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                grp_q <= grp_in;
                nmi_q <= hppi_nmi;
                if (rd_normal) begin
                    id_q  <= normal_id;
                    act_q <= normal_act;
                end else if (rd_nmi) begin
                    id_q  <= nmi_id;
                    act_q <= nmi_act;
                end
            end
        end
    end

    // Outputs per state
    always_comb begin
        ack_valid = 1'b0;
        ack_id    = ID_SPURIOUS;
        act_pulse = 1'b0;
        act_id    = id_q;
        act_grp   = grp_q;
        act_nmi   = nmi_q;
        unique case (state_q)
            ST_IDLE: begin
                ack_valid = 1'b0;
            end
            ST_NORMAL_RESP, ST_NMI_RESP: begin
                ack_valid = 1'b1;
                ack_id    = id_q;
                act_pulse = act_q;
            end
            default: begin
                ack_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/nmi_ack_unit_chk.sv
module nmi_ack_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_normal,
    input logic       rd_nmi,
    input logic       ack_valid,
    input logic [9:0] ack_id,
    input logic       act_pulse,
    input logic [9:0] act_id,
    input logic       act_nmi
);
    // R1
    strobe_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_normal || rd_nmi) && !ack_valid) |=> ack_valid);

    // R1
    single_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);

    // R10
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_pulse |=> !act_pulse);

    // R10
    pulse_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_pulse |-> (ack_valid && (act_id == ack_id)));

    // R9
    no_special_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_pulse |-> (act_id < 10'd1020));

    // R8
    nmi_port_only_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pulse && $past(rd_nmi && !rd_normal && !ack_valid)) |-> act_nmi);
endmodule

bind nmi_ack_unit nmi_ack_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_normal (rd_normal),
    .rd_nmi    (rd_nmi),
    .ack_valid (ack_valid),
    .ack_id    (ack_id),
    .act_pulse (act_pulse),
    .act_id    (act_id),
    .act_nmi   (act_nmi)
);

// File: tb/nmi_ack_unit_test.sv
module nmi_ack_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_normal = 1'b0, rd_nmi = 1'b0;
    logic       hppi_valid = 1'b0;
    logic [9:0] hppi_id = '0;
    logic [7:0] hppi_prio = '0;
    logic [1:0] hppi_grp = '0;
    logic       hppi_nmi = 1'b0;
    logic [7:0] pmr = '0, rpr = 8'hFF, bpr_mask = 8'hFF;
    logic       act_nmi_g1s = 1'b0, act_nmi_g1ns = 1'b0;
    logic       cpu_secure = 1'b0, sec_disabled = 1'b0, nmi_en = 1'b0;
    logic       ack_valid, act_pulse, act_nmi;
    logic [9:0] ack_id, act_id;
    logic [1:0] act_grp;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    nmi_ack_unit uut (
        .clk(clk), .rst_n(rst_n), .rd_normal(rd_normal), .rd_nmi(rd_nmi),
        .hppi_valid(hppi_valid), .hppi_id(hppi_id), .hppi_prio(hppi_prio),
        .hppi_grp(hppi_grp), .hppi_nmi(hppi_nmi), .pmr(pmr), .rpr(rpr),
        .bpr_mask(bpr_mask), .act_nmi_g1s(act_nmi_g1s), .act_nmi_g1ns(act_nmi_g1ns),
        .cpu_secure(cpu_secure), .sec_disabled(sec_disabled), .nmi_en(nmi_en),
        .ack_valid(ack_valid), .ack_id(ack_id), .act_pulse(act_pulse),
        .act_id(act_id), .act_grp(act_grp), .act_nmi(act_nmi)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       valid;
        logic       use_nmi_port;
        logic [9:0] id;
        logic [7:0] prio;
        logic [1:0] grp;
        logic       nmi;
        logic [7:0] pmr;
        logic [7:0] rpr;
        logic       as, ans, sec, ds, en;
        logic [9:0] exp_id;
        logic       exp_act;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{4'd5, 1, 0, 10'd40,   8'h20, 2'd2, 0, 8'hF0, 8'hFF, 0,0,0,0,0, 10'd40,   1}, // R5 plain take
        '{4'd3, 1, 0, 10'd40,   8'h20, 2'd2, 0, 8'h20, 8'hFF, 0,0,0,0,0, 10'd1023, 0}, // R3 prio == pmr
        '{4'd5, 1, 0, 10'd41,   8'h30, 2'd1, 0, 8'hF0, 8'h30, 0,0,0,0,0, 10'd1023, 0}, // R5 equal rpr
        '{4'd7, 1, 0, 10'd50,   8'h40, 2'd1, 1, 8'h10, 8'hFF, 0,0,0,0,1, 10'd1022, 0}, // R7 enabled NMI
        '{4'd7, 1, 0, 10'd50,   8'h40, 2'd1, 1, 8'h10, 8'hFF, 0,0,0,0,0, 10'd50,   1}, // R7 disabled
        '{4'd8, 1, 1, 10'd50,   8'h40, 2'd1, 1, 8'h10, 8'hFF, 0,0,0,0,1, 10'd50,   1}, // R8 NMI port NMI
        '{4'd8, 1, 1, 10'd40,   8'h20, 2'd2, 0, 8'hF0, 8'hFF, 0,0,0,0,0, 10'd1023, 0}, // R8 non-NMI
        '{4'd4, 1, 1, 10'd60,   8'h40, 2'd2, 1, 8'h70, 8'hFF, 0,0,0,0,0, 10'd1023, 0}, // R4 pmr < 0x80
        '{4'd4, 1, 1, 10'd60,   8'h40, 2'd2, 1, 8'h80, 8'hFF, 0,0,1,0,0, 10'd1023, 0}, // R4 secure 0x80
        '{4'd4, 1, 1, 10'd60,   8'h40, 2'd2, 1, 8'h80, 8'hFF, 0,0,0,0,0, 10'd60,   1}, // R4 nonsecure 0x80
        '{4'd4, 1, 1, 10'd60,   8'h40, 2'd2, 1, 8'h10, 8'hFF, 0,0,1,1,0, 10'd60,   1}, // R4 sec disabled
        '{4'd6, 1, 1, 10'd70,   8'h40, 2'd1, 1, 8'hF0, 8'h40, 0,0,0,0,0, 10'd70,   1}, // R6 equal, none active
        '{4'd6, 1, 1, 10'd70,   8'h40, 2'd1, 1, 8'hF0, 8'h40, 1,0,0,0,0, 10'd1023, 0}, // R6 own active
        '{4'd6, 1, 1, 10'd70,   8'h40, 2'd1, 1, 8'hF0, 8'h40, 0,1,0,0,0, 10'd70,   1}, // R6 other active
        '{4'd9, 1, 0, 10'd1021, 8'h10, 2'd2, 0, 8'hF0, 8'hFF, 0,0,0,0,0, 10'd1021, 0}, // R9 normal port
        '{4'd9, 1, 1, 10'd1020, 8'h10, 2'd1, 1, 8'hF0, 8'hFF, 0,0,0,0,0, 10'd1020, 0}, // R9 NMI port
        '{4'd2, 0, 0, 10'd40,   8'h20, 2'd2, 0, 8'hF0, 8'hFF, 0,0,0,0,0, 10'd1023, 0}, // R2 nothing pending
        '{4'd4, 1, 0, 10'd80,   8'h50, 2'd0, 1, 8'h10, 8'hFF, 0,0,0,0,0, 10'd80,   1}  // R4 group-0 NMI
    };

    task automatic check(input bit ok, input string tag, input int actual, input int expected);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic apply(input vec_t v);
        hppi_valid = v.valid; hppi_id = v.id; hppi_prio = v.prio;
        hppi_grp = v.grp; hppi_nmi = v.nmi; pmr = v.pmr; rpr = v.rpr;
        act_nmi_g1s = v.as; act_nmi_g1ns = v.ans; cpu_secure = v.sec;
        sec_disabled = v.ds; nmi_en = v.en;
    endtask

    // strobe for one cycle, then sample at the next falling edge
    task automatic strobe(input bit n, input bit m);
        @(negedge clk);
        rd_normal = n; rd_nmi = m;
        @(negedge clk);
        rd_normal = 0; rd_nmi = 0;
    endtask

    initial begin
        #1500000;
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!ack_valid && !act_pulse, "R1 reset idle", int'(ack_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ack_valid && !act_pulse, "R10 no pulse after reset", int'(act_pulse), 0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            strobe(!VECS[i].use_nmi_port, VECS[i].use_nmi_port);
            check(ack_valid, $sformatf("R%0d vec%0d valid", VECS[i].req, i), int'(ack_valid), 1);
            check(ack_id == VECS[i].exp_id, $sformatf("R%0d vec%0d id", VECS[i].req, i),
                  int'(ack_id), int'(VECS[i].exp_id));
            check(act_pulse == VECS[i].exp_act, $sformatf("R%0d vec%0d act", VECS[i].req, i),
                  int'(act_pulse), int'(VECS[i].exp_act));
            if (VECS[i].exp_act) begin
                check(act_id == VECS[i].id && act_grp == VECS[i].grp && act_nmi == VECS[i].nmi,
                      $sformatf("R10 vec%0d payload", i), int'(act_id), int'(VECS[i].id));
            end
            @(negedge clk);
            check(!ack_valid && !act_pulse, $sformatf("R10 vec%0d one cycle", i),
                  int'(act_pulse), 0);
        end

        // R5: binary-point mask lowers group priority 0x2C to 0x20 < 0x28
        apply('{4'd5, 1, 0, 10'd33, 8'h2C, 2'd2, 0, 8'hF0, 8'h28, 0,0,0,0,0, 10'd33, 1});
        strobe(1, 0);
        check(ack_id == 10'd1023, "R5 full mask blocks", int'(ack_id), 1023);
        bpr_mask = 8'hF0;
        strobe(1, 0);
        check(ack_id == 10'd33 && act_pulse, "R5 coarse mask preempts", int'(ack_id), 33);
        bpr_mask = 8'hFF;

        // R1: both strobes, ordinary wins -> enabled NMI gives 1022
        apply(VECS[5]);
        strobe(1, 1);
        check(ack_id == 10'd1022 && !act_pulse, "R1 normal wins", int'(ack_id), 1022);

        // R1: strobe held through the response cycle is not taken twice
        @(negedge clk);
        rd_nmi = 1;
        @(negedge clk);
        check(ack_valid && ack_id == 10'd50, "R1 held strobe first", int'(ack_id), 50);
        @(negedge clk);
        rd_nmi = 0;
        check(!ack_valid, "R1 held strobe ignored", int'(ack_valid), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule